// File: doc/BRIEF.md
# Protection Region Register Bank

This block holds the programmed settings of a set of memory protection regions behind a small register window. The window has three words. The first is a selector that names the current region. The second is the base address of that region. The third holds the size and enable halfword in its lower half and the attribute halfword in its upper half. Software picks a region by writing the selector and then reads or writes the other two words. Those accesses reach only the region that the selector names. Matching accesses against the regions and raising faults are done by other logic.

The bus is a single-cycle register port with byte strobes. A halfword store needs only the two matching strobes. Strobes 0011 on word 2 (byte offset 0x8) change the size/enable halfword, and strobes 1100 on word 2 (byte offset 0xA) change the attribute halfword. Reads are combinational from the current state.

A base-address write that sets its valid flag also moves the selector to the region number carried in that same word. The base is stored into that new region. A region can therefore be programmed with two word writes: one packed base word, then one size/attribute word. An ordered burst of three words to offsets 0x0, 0x4 and 0x8 does the same work in three writes.

The word offset is decoded into one of four named register selects:
- `SEL_NUM`: word 0, the region selector.
- `SEL_BASE`: word 1, the base address.
- `SEL_CTRL`: word 2, size/enable and attribute.
- `SEL_NONE`: word 3, or no access.

A store in `SEL_BASE` with the valid flag set takes the retarget path. Every other store updates the decoded register in place.

Top module: `prot_region_bank`

## Requirements
- R1: After reset, the selector reads 0. Every region reads back a base of 0, a size/enable halfword of 0 (region disabled) and an attribute halfword of 0.
- R2: A write to word 0 with strobe 0 set loads the selector from wdata[IDX_W-1:0]. Reading word 0 returns the selector zero-extended to 32 bits.
- R3: Word 1 reads the selected region's base in bits [31:5], 0 in bit 4 (the valid flag) and the selector in bits [3:0]. A write to word 1 stores bits [31:5] into the selected region only.
- R4: A word-1 write with strobe 0 set and wdata[4]=1 loads the selector from wdata[IDX_W-1:0] and, in the same cycle, stores the base into that newly named region.
- R5: A word-1 write with wdata[4]=0 leaves the selector unchanged.
- R6: In word 2, strobes 0011 change only the size/enable halfword (bits [15:0], bit 0 = enable). Strobes 1100 change only the attribute halfword (bits [31:16]). Both act on the selected region.
- R7: For every register, only the byte lanes whose strobe is set are updated.
- R8: An access with sel_i=0, or with we_i=0, changes no state. Word 3 reads as 0, and writes to it are ignored.
- R9: Writing one region leaves the stored contents of every other region unchanged.
- R10: Three consecutive word writes to words 0, 1 and 2, in that order, fully program the named region with its number, base, size/enable and attributes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| word_addr_i | input | 2 | Word offset within the window (byte offset / 4) |
| wdata_i | input | 32 | Write data |
| wstrb_i | input | 4 | Byte strobes, bit n enables byte lane n |
| rdata_o | output | 32 | Read data for the addressed word |

## Verification
The bench goes after the cases below, each with the fault that would expose it:
- **Retargeting base write.** A design that stores the base through the old selector would leave the base in the previous region and return wrong numbers from the selector.
- **Halfword stores to the control word.** A design that ignores the strobes would wipe the attribute halfword when only the enable is rewritten.
- **Cross-region isolation.** Every region is swept and read back after all the others have been written, so a decode that aliases region indices shows up as corrupted neighbours.
- **Disabled and unmapped accesses.** Writes with the select or the write enable low, and stores to word 3, must leave all readable state unchanged.

// File: rtl/prb_pkg.sv
package prb_pkg;
    localparam int RFIELD_W  = 4;
    localparam int VALID_BIT = 4;
    localparam int BASE_LSB  = 5;

    typedef enum logic [1:0] {
        SEL_NUM  = 2'd0,
        SEL_BASE = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/prb_decode.sv
module prb_decode
    import prb_pkg::*;
(
    input  logic       sel_i,
    input  logic       we_i,
    input  logic [1:0] word_addr_i,
    output reg_sel_e   reg_sel_o,
    output logic       wr_num_o,
    output logic       wr_base_o,
    output logic       wr_ctrl_o
);
    always_comb begin
        reg_sel_o = SEL_NONE;
        if (sel_i) begin
            unique case (word_addr_i)
                2'd0:    reg_sel_o = SEL_NUM;
                2'd1:    reg_sel_o = SEL_BASE;
                2'd2:    reg_sel_o = SEL_CTRL;
                default: reg_sel_o = SEL_NONE;
            endcase
        end
    end

    always_comb begin
        wr_num_o  = 1'b0;
        wr_base_o = 1'b0;
        wr_ctrl_o = 1'b0;
        if (we_i) begin
            unique case (reg_sel_o)
                SEL_NUM:  wr_num_o  = 1'b1;
                SEL_BASE: wr_base_o = 1'b1;
                SEL_CTRL: wr_ctrl_o = 1'b1;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/prb_region_entry.sv
module prb_region_entry
    import prb_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 base_we_i,
    input  logic                 ctrl_we_i,
    input  logic [31:0]          wdata_i,
    input  logic [31:0]          wmask_i,
    output logic [31:BASE_LSB]   base_q_o,
    output logic [15:0]          ctrl_q_o,
    output logic [15:0]          attr_q_o
);
    logic [31:0] base_full, base_next, cw_full, cw_next;

    always_comb begin
        base_full = {base_q_o, {BASE_LSB{1'b0}}};
        base_next = (base_full & ~wmask_i) | (wdata_i & wmask_i);
        cw_full   = {attr_q_o, ctrl_q_o};
        cw_next   = (cw_full & ~wmask_i) | (wdata_i & wmask_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            base_q_o <= '0;
            ctrl_q_o <= '0;
            attr_q_o <= '0;
        end else begin
            if (base_we_i) base_q_o <= base_next[31:BASE_LSB];
            if (ctrl_we_i) begin
                ctrl_q_o <= cw_next[15:0];
                attr_q_o <= cw_next[31:16];
            end
        end
    end

    AST_ENTRY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!base_we_i && !ctrl_we_i) |=> ($stable(base_q_o) && $stable(ctrl_q_o) && $stable(attr_q_o))); // R9
    AST_ATTR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_we_i && wmask_i[31:16] == 16'h0) |=> $stable(attr_q_o)); // R6
    AST_SIZE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_we_i && wmask_i[15:0] == 16'h0) |=> $stable(ctrl_q_o)); // R6
endmodule

// File: rtl/prot_region_bank.sv
module prot_region_bank
    import prb_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        sel_i,
    input  logic        we_i,
    input  logic [1:0]  word_addr_i,
    input  logic [31:0] wdata_i,
    input  logic [3:0]  wstrb_i,
    output logic [31:0] rdata_o
);
    localparam int IDX_W = $clog2(NUM_REGIONS);
    localparam int PAD_W = BASE_LSB - IDX_W;

    reg_sel_e          reg_sel;
    logic              wr_num, wr_base, wr_ctrl;
    logic [IDX_W-1:0]  cur_idx;
    logic [IDX_W-1:0]  tgt_idx;
    logic              retarget;
    logic [31:0]       wmask;

    logic [31:BASE_LSB] base_arr [NUM_REGIONS];
    logic [15:0]        ctrl_arr [NUM_REGIONS];
    logic [15:0]        attr_arr [NUM_REGIONS];

    prb_decode u_dec (
        .sel_i       (sel_i),
        .we_i        (we_i),
        .word_addr_i (word_addr_i),
        .reg_sel_o   (reg_sel),
        .wr_num_o    (wr_num),
        .wr_base_o   (wr_base),
        .wr_ctrl_o   (wr_ctrl)
    );

    always_comb begin
        for (int b = 0; b < 4; b++) wmask[b*8 +: 8] = {8{wstrb_i[b]}};
        retarget = wr_base && wstrb_i[0] && wdata_i[VALID_BIT];
        tgt_idx  = retarget ? wdata_i[IDX_W-1:0] : cur_idx;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_idx <= '0;
        end else if ((wr_num && wstrb_i[0]) || retarget) begin
            cur_idx <= wdata_i[IDX_W-1:0];
        end
    end

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        prb_region_entry u_entry (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .base_we_i (wr_base && (tgt_idx == IDX_W'(g))),
            .ctrl_we_i (wr_ctrl && (cur_idx == IDX_W'(g))),
            .wdata_i   (wdata_i),
            .wmask_i   (wmask),
            .base_q_o  (base_arr[g]),
            .ctrl_q_o  (ctrl_arr[g]),
            .attr_q_o  (attr_arr[g])
        );
    end

    always_comb begin
        rdata_o = '0;
        unique case (reg_sel)
            SEL_NUM:  rdata_o = {{(32-IDX_W){1'b0}}, cur_idx};
            SEL_BASE: rdata_o = {base_arr[cur_idx], {PAD_W{1'b0}}, cur_idx};
            SEL_CTRL: rdata_o = {attr_arr[cur_idx], ctrl_arr[cur_idx]};
            default:  rdata_o = '0;
        endcase
    end

    AST_NUM_RETARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && we_i && word_addr_i == 2'd1 && wstrb_i[0] && wdata_i[VALID_BIT])
        |=> (cur_idx == $past(wdata_i[IDX_W-1:0]))); // R4
    AST_NUM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(sel_i && we_i && (word_addr_i == 2'd0 || (word_addr_i == 2'd1 && wdata_i[VALID_BIT])))
        |=> $stable(cur_idx)); // R5
    AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && word_addr_i == 2'd3) |-> (rdata_o == 32'h0)); // R8
    AST_VALID_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && word_addr_i == 2'd1) |-> (rdata_o[VALID_BIT] == 1'b0)); // R3
endmodule

// File: tb/prot_region_bank_tb.sv
module prot_region_bank_tb_top;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, we = 1'b0;
    logic [1:0]  wa = 2'd0;
    logic [31:0] wd = '0;
    logic [3:0]  ws = '0;
    logic [31:0] rd;

    int checks = 0, errors = 0;
    logic [31:0] m_base [N];
    logic [31:0] m_cw   [N];
    logic [2:0]  m_idx;

    always #10 clk = ~clk;

    prot_region_bank #(.NUM_REGIONS(N)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we),
        .word_addr_i(wa), .wdata_i(wd), .wstrb_i(ws), .rdata_o(rd)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] lanes(input logic [3:0] s);
        for (int b = 0; b < 4; b++) lanes[b*8 +: 8] = {8{s[b]}};
    endfunction

    task automatic model_wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] s);
        logic [31:0] m;
        logic [2:0] t;
        m = lanes(s);
        case (a)
            2'd0: if (s[0]) m_idx = d[2:0];
            2'd1: begin
                t = (s[0] && d[4]) ? d[2:0] : m_idx;
                m_idx = t;
                m_base[t] = ((m_base[t] & ~m) | (d & m)) & 32'hFFFF_FFE0;
            end
            2'd2: m_cw[m_idx] = (m_cw[m_idx] & ~m) | (d & m);
            default: ;
        endcase
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] s,
                          input logic en = 1'b1);
        @(negedge clk);
        sel = en; we = 1'b1; wa = a; wd = d; ws = s;
        @(posedge clk);
        #1 sel = 1'b0; we = 1'b0;
        if (en) model_wr(a, d, s);
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b0; wa = a; ws = 4'h0;
        #2 d = rd;
        sel = 1'b0;
    endtask

    task automatic check_region(input int r, input string tag);
        logic [31:0] v;
        bus_wr(2'd0, 32'(r), 4'h1);
        bus_rd(2'd0, v); chk({tag, " num"}, v, 32'(r));
        bus_rd(2'd1, v); chk({tag, " base"}, v, m_base[r] | 32'(r));
        bus_rd(2'd2, v); chk({tag, " ctrl"}, v, m_cw[r]);
    endtask

    initial begin
        logic [31:0] v;
        for (int i = 0; i < N; i++) begin m_base[i] = '0; m_cw[i] = '0; end
        m_idx = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        bus_rd(2'd0, v); chk("R1 selector", v, 32'h0);
        for (int r = 0; r < N; r++) check_region(r, "R1");

        // R2: selector writes (low bits only), R3: base via selector
        bus_wr(2'd0, 32'hFFFF_FF0D, 4'h1);
        bus_rd(2'd0, v); chk("R2 selector trunc", v, 32'h5);
        bus_wr(2'd0, 32'h2, 4'h0);
        bus_rd(2'd0, v); chk("R7 selector no strobe", v, 32'h5);

        // R10: ordered burst for every region, R9 isolation
        for (int r = 0; r < N; r++) begin
            bus_wr(2'd0, 32'(r), 4'hF);
            bus_wr(2'd1, 32'h1000_0000 * (r + 1) + 32'h0000_0A4F & ~32'h10, 4'hF);
            bus_wr(2'd2, {16'(16'h0300 + r), 16'(16'h0020 + 2 * r + 1)}, 4'hF);
        end
        for (int r = 0; r < N; r++) check_region(r, "R10/R9");

        // R6: halfword at 0x8 clears enable only; at 0xA changes attributes only
        bus_wr(2'd0, 32'd3, 4'h1);
        bus_wr(2'd2, 32'hAAAA_0000, 4'h3);
        bus_rd(2'd2, v); chk("R6 size half", v, m_cw[3]);
        bus_wr(2'd2, 32'h7E5A_FFFF, 4'hC);
        bus_rd(2'd2, v); chk("R6 attr half", v, m_cw[3]);
        check_region(2, "R9 neighbour");

        // R7: single byte lanes on base and control
        bus_wr(2'd0, 32'd6, 4'h1);
        bus_wr(2'd1, 32'hDEAD_BEEF & ~32'h10, 4'h4);
        bus_rd(2'd1, v); chk("R7 base lane2", v, m_base[6] | 32'd6);
        bus_wr(2'd2, 32'h1122_3344, 4'h2);
        bus_rd(2'd2, v); chk("R7 ctrl lane1", v, m_cw[6]);

        // R5: VALID=0 keeps selector
        bus_wr(2'd1, 32'h5550_0002, 4'hF);
        bus_rd(2'd0, v); chk("R5 selector kept", v, 32'd6);
        bus_rd(2'd1, v); chk("R3 base in selected", v, m_base[6] | 32'd6);

        // R4: two-word programming for every region
        for (int r = 0; r < N; r++) begin
            bus_wr(2'd1, 32'h0800_0000 * (r + 1) + 32'h40 + 32'h10 + 32'(r), 4'hF);
            bus_rd(2'd0, v); chk("R4 retarget", v, 32'(r));
            bus_wr(2'd2, {16'(16'hC000 | r), 16'h0013}, 4'hF);
        end
        for (int r = 0; r < N; r++) check_region(r, "R4 sweep");

        // R8: disabled and unmapped accesses
        bus_wr(2'd2, 32'h0, 4'hF, 1'b0);
        bus_wr(2'd1, 32'h0000_0011, 4'hF, 1'b0);
        bus_wr(2'd3, 32'hFFFF_FFFF, 4'hF);
        bus_rd(2'd3, v); chk("R8 unmapped read", v, 32'h0);
        @(negedge clk); sel = 1'b0; we = 1'b1; wa = 2'd2; wd = '0; ws = 4'hF;
        @(posedge clk); #1 we = 1'b0;
        for (int r = 0; r < N; r++) check_region(r, "R8 unchanged");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule